// File: doc/BRIEF.md
# Read Output Stage with Selectable Deselect Timing

This block sits between a synchronous memory array and its data pins. It decides when read data reaches the pins and when the output drivers are switched on or off. The command for each cycle is sampled on the rising clock edge, and the array supplies the matching word during the following cycle. In pipelined mode that word is loaded into an output register, so it appears one clock later. In flow-through mode the word goes straight to the pins in the cycle it is produced.

A deselect turns the drivers off. In dual-cycle mode the turn-off travels down the same number of stages as read data. In single-cycle mode it takes effect one stage sooner. Between a read and the next deselect, a selected cycle that carries no read keeps the last word on the pins. An asynchronous output enable is applied last to the driver enable, outside any clocking.

Top module: `rd_out_pipe`

## Requirements
- R1: While rst_ni is low, dq_oe_o is low and dq_o is all zeros.
- R2: With pipe_mode_i = 1, a read (ce_i = 1, rd_i = 1) sampled at edge n drives dq_o from edge n+1 to edge n+2, with dq_oe_o high. The value is the arr_data_i present at edge n+1.
- R3: With pipe_mode_i = 0, a read sampled at edge n drives from edge n to edge n+1, and dq_o follows arr_data_i combinationally during that cycle.
- R4: A selected cycle with no read (ce_i = 1, rd_i = 0) keeps the drivers in their previous state. When they are on, dq_o holds the last word read.
- R5: With pipe_mode_i = 1 and dcd_mode_i = 1, a deselect (ce_i = 0) sampled at edge n turns dq_oe_o off from edge n+1.
- R6: With pipe_mode_i = 1 and dcd_mode_i = 0, a deselect sampled at edge n turns dq_oe_o off from edge n. The exception is a read sampled at edge n-1: it still drives its full slot.
- R7: A read issued in the cycle right after a deselect drives its data in its normal slot, in both data modes.
- R8: With pipe_mode_i = 0, a deselect sampled at edge n turns dq_oe_o off from edge n, whatever the value of dcd_mode_i.
- R9: oe_i = 0 forces dq_oe_o low at once, with no clock edge needed. Raising oe_i again restores the clocked enable at once.
- R10: Back-to-back reads give one new word per cycle. The first word lands one cycle after the command in flow-through mode and two cycles after it in pipelined mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip select; 0 is a deselect command |
| rd_i | input | 1 | Read command when ce_i is 1 |
| arr_data_i | input | DW | Word from the array for the access in progress |
| pipe_mode_i | input | 1 | 1 = pipelined, 0 = flow-through |
| dcd_mode_i | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| oe_i | input | 1 | Asynchronous output enable, active high |
| dq_o | output | DW | Output data |
| dq_oe_o | output | 1 | Tristate driver enable |

## Verification
The hardest case to reach is a single-cycle deselect in pipelined mode that collides with read data. It takes a read followed directly by a deselect, which checks that the read keeps its slot. It also takes a read, a selected idle cycle and then a deselect, which is the only pattern where the two deselect modes give different enable waveforms. Each mode is set while reset is held, and the same command sequence is then replayed under both deselect settings. Every cycle of the sequence carries an expected enable and an expected word.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_HOLD  = 2'd2
  } rdp_cmd_e;
endpackage

// File: rtl/rdp_cmd_pipe.sv
module rdp_cmd_pipe
  import rdp_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ce_i,
  input  logic     rd_i,
  output rdp_cmd_e s1_o,
  output rdp_cmd_e s2_o
);
  rdp_cmd_e cmd_in;
  rdp_cmd_e stage_q [DEPTH];

  always_comb begin
    if (!ce_i)     cmd_in = CMD_DESEL;
    else if (rd_i) cmd_in = CMD_READ;
    else           cmd_in = CMD_HOLD;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= CMD_DESEL;
      else if (g == 0) stage_q[g] <= cmd_in;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign s1_o = stage_q[0];
  assign s2_o = stage_q[DEPTH-1];
endmodule

// File: rtl/rdp_data_path.sv
module rdp_data_path
  import rdp_pkg::*;
#(
  parameter int unsigned DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rdp_cmd_e      s1_i,
  input  logic          pipe_mode_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] dq_o
);
  logic [DW-1:0] data_q;

  // loads the word of the access in progress; doubles as hold register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (s1_i == CMD_READ) data_q <= arr_data_i;
  end

  always_comb begin
    if (pipe_mode_i)            dq_o = data_q;
    else if (s1_i == CMD_READ)  dq_o = arr_data_i;
    else                        dq_o = data_q;
  end
endmodule

// File: rtl/rdp_drive_ctl.sv
module rdp_drive_ctl
  import rdp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rdp_cmd_e s1_i,
  input  rdp_cmd_e s2_i,
  input  logic     pipe_mode_i,
  input  logic     dcd_mode_i,
  output logic     drv_o
);
  logic hold_q;
  logic early_off;

  // single-cycle deselect cuts holding one stage ahead of data
  assign early_off = !dcd_mode_i && (s1_i == CMD_DESEL);

  always_comb begin
    if (pipe_mode_i)
      drv_o = (s2_i == CMD_READ) ||
              (hold_q && (s2_i != CMD_DESEL) && !early_off);
    else
      drv_o = (s1_i == CMD_READ) || (hold_q && (s1_i != CMD_DESEL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= drv_o;
  end
endmodule

// File: rtl/rd_out_pipe.sv
module rd_out_pipe
  import rdp_pkg::*;
#(
  parameter int unsigned DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          rd_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          pipe_mode_i,
  input  logic          dcd_mode_i,
  input  logic          oe_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  rdp_cmd_e s1, s2;
  logic     drv;

  rdp_cmd_pipe #(.DEPTH(2)) u_cmd (
    .clk_i (clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .rd_i(rd_i),
    .s1_o  (s1), .s2_o(s2)
  );

  rdp_data_path #(.DW(DW)) u_data (
    .clk_i      (clk_i), .rst_ni(rst_ni), .s1_i(s1),
    .pipe_mode_i(pipe_mode_i), .arr_data_i(arr_data_i), .dq_o(dq_o)
  );

  rdp_drive_ctl u_drv (
    .clk_i      (clk_i), .rst_ni(rst_ni), .s1_i(s1), .s2_i(s2),
    .pipe_mode_i(pipe_mode_i), .dcd_mode_i(dcd_mode_i), .drv_o(drv)
  );

  // asynchronous final gate
  assign dq_oe_o = drv && oe_i;
endmodule

// File: rtl/rd_out_pipe_chk.sv
module rd_out_pipe_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_i,
  input logic          rd_i,
  input logic [DW-1:0] arr_data_i,
  input logic          pipe_mode_i,
  input logic          dcd_mode_i,
  input logic          oe_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!dq_oe_o && dq_o == '0); // R1
    end
  end

  AST_PIPE_READ_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && $past(pipe_mode_i) && $past(pipe_mode_i, 2) && oe_i &&
     $past(ce_i && rd_i, 2)) |-> (dq_oe_o && dq_o == $past(arr_data_i))); // R2

  AST_FT_READ_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !$past(pipe_mode_i) && oe_i && $past(ce_i && rd_i))
    |-> (dq_oe_o && dq_o == arr_data_i)); // R3

  AST_DCD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && dcd_mode_i && $past(pipe_mode_i) && $past(dcd_mode_i) &&
     $past(pipe_mode_i, 2) && $past(dcd_mode_i, 2) && !$past(ce_i, 2))
    |-> !dq_oe_o); // R5

  AST_SCD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !dcd_mode_i && $past(pipe_mode_i) && !$past(dcd_mode_i) &&
     !$past(ce_i) && !$past(ce_i && rd_i, 2)) |-> !dq_oe_o); // R6

  AST_FT_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !$past(pipe_mode_i) && !$past(ce_i)) |-> !dq_oe_o); // R8
endmodule

bind rd_out_pipe rd_out_pipe_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .rd_i(rd_i),
  .arr_data_i(arr_data_i), .pipe_mode_i(pipe_mode_i), .dcd_mode_i(dcd_mode_i),
  .oe_i(oe_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
);

// File: tb/tb_rd_out_pipe.sv
module tb_rd_out_pipe;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] arr_data_i = '0;
  logic          pipe_mode_i = 1'b1, dcd_mode_i = 1'b0, oe_i = 1'b1;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rd_out_pipe #(.DW(DW)) dut (.*);

  task automatic check(input logic eoe, input logic [DW-1:0] edq, input string req);
    n_chk++;
    if (dq_oe_o !== eoe) begin
      n_fail++;
      $display("FAIL %s: dq_oe_o=%b expected %b at %0t", req, dq_oe_o, eoe, $time);
    end else if (eoe && dq_o !== edq) begin
      n_fail++;
      $display("FAIL %s: dq_o=%h expected %h at %0t", req, dq_o, edq, $time);
    end
  endtask

  // apply the command for the next edge and the array word of the access in progress, then check
  task automatic cyc(input logic ce, input logic rd, input logic [DW-1:0] arr,
                     input logic eoe, input logic [DW-1:0] edq, input string req);
    @(negedge clk_i);
    ce_i = ce; rd_i = rd; arr_data_i = arr;
    #1 check(eoe, edq, req);
  endtask

  task automatic do_reset(input logic pm, input logic dm);
    @(negedge clk_i);
    rst_ni = 1'b0; ce_i = 1'b0; rd_i = 1'b0; arr_data_i = '1;
    pipe_mode_i = pm; dcd_mode_i = dm; oe_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    arr_data_i = '0;
    #1 check(1'b0, '0, "R1 reset quiet");
    if (dq_o !== '0) begin
      n_fail++;
      $display("FAIL R1: dq_o=%h expected 0", dq_o);
    end
    n_chk++;
    rst_ni = 1'b1;
  endtask

  // pipelined: read, read, idle, deselect, read, idle, idle, deselect, deselect
  task automatic test_pipe(input logic dcd);
    do_reset(1'b1, dcd);
    cyc(1, 1, 16'h0000, 0, 0,        "R2 first read not yet");
    cyc(1, 1, 16'hA1A1, 0, 0,        "R10 pipe latency");
    cyc(1, 0, 16'hA2A2, 1, 16'hA1A1, "R2 first word");
    cyc(0, 0, 16'hA3A3, 1, 16'hA2A2, "R10 second word");
    cyc(1, 1, 16'h5555, dcd, 16'hA2A2, dcd ? "R5 dcd holds" : "R6 scd early off");
    cyc(1, 0, 16'hB1B1, 0, 0,        "R5 off at deselect slot");
    cyc(1, 0, 16'h6666, 1, 16'hB1B1, "R7 read after deselect");
    cyc(0, 0, 16'h7777, 1, 16'hB1B1, "R4 hold last word");
    cyc(0, 0, 16'h8888, dcd, 16'hB1B1, dcd ? "R5 dcd holds" : "R6 scd early off");
    cyc(1, 1, 16'h9999, 0, 0,        "R5 deselected");
    // read directly followed by deselect keeps its slot
    cyc(0, 0, 16'hC1C1, 0, 0,        "R6 pre");
    cyc(0, 0, 16'hC2C2, 1, 16'hC1C1, "R6 read keeps slot");
    cyc(0, 0, 16'hC3C3, 0, 0,        "R6 off after slot");
  endtask

  task automatic test_ft(input logic dcd);
    do_reset(1'b0, dcd);
    cyc(1, 1, 16'h0000, 0, 0,        "R3 pre");
    cyc(1, 0, 16'hF1F1, 1, 16'hF1F1, "R3 flow-through word");
    #1 arr_data_i = 16'hF2F2;
    #1 check(1'b1, 16'hF2F2,         "R3 combinational follow");
    cyc(1, 1, 16'hF3F3, 1, 16'hF2F2, "R4 ft hold");
    cyc(0, 0, 16'hF4F4, 1, 16'hF4F4, "R10 ft next word");
    cyc(1, 1, 16'hF5F5, 0, 0,        "R8 ft deselect off");
    cyc(1, 0, 16'hF6F6, 1, 16'hF6F6, "R7 ft read after deselect");
    cyc(0, 0, 16'hF7F7, 1, 16'hF6F6, "R4 ft hold");
    cyc(0, 0, 16'hF8F8, 0, 0,        "R8 ft off");
  endtask

  task automatic test_oe();
    do_reset(1'b1, 1'b1);
    cyc(1, 1, 16'h0000, 0, 0,        "R9 pre");
    cyc(1, 0, 16'hD1D1, 0, 0,        "R9 pre");
    cyc(1, 0, 16'hD2D2, 1, 16'hD1D1, "R9 driving");
    #1 oe_i = 1'b0;
    #1 check(1'b0, '0,               "R9 async off");
    #1 oe_i = 1'b1;
    #1 check(1'b1, 16'hD1D1,         "R9 async restore");
    cyc(0, 0, 16'hD3D3, 1, 16'hD1D1, "R4 hold after oe pulse");
  endtask

  initial begin
    test_pipe(1'b1);
    test_pipe(1'b0);
    test_ft(1'b0);
    test_ft(1'b1);
    test_oe();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule